// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block accepts bytes from a host over a valid/ready write port and holds them in a small circular byte store. It sends each stored byte as an asynchronous serial frame on one output line. The line rests high. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit.

Bit timing comes from a sub-tick strobe that the surrounding logic pulses at sixteen times the bit rate. A bit-cell counter counts those strobes, so every bit lasts exactly sixteen of them. A separate data-bit counter with advance and clear controls tells the sequencer when the eighth data bit has gone out. While the store holds bytes, frames follow one another with no idle gap. A busy flag marks the time a frame is on the line.

Back-pressure works as follows. `in_ready` is high whenever the store has a free slot. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. If `in_valid` is raised while the store is full, nothing is written and the byte is lost. The host may hold `in_valid` until it sees `in_ready`.

Top module: `uart_txb`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0, `empty` is 1, `full` is 0 and `in_ready` is 1; `tx_line` is 1 whenever `busy` is 0.
- R2: Each frame drives `tx_line` low for the start bit, then sends data bits 0 through 7 in that order, then drives it high for the stop bit.
- R3: Every bit of a frame lasts exactly 16 sub-tick pulses, and while `busy` is held, `tx_line` changes only in a cycle that follows a cycle with `sub_tick` high.
- R4: Sub-tick pulses received while idle have no effect, so every start bit still lasts a full 16 sub-ticks.
- R5: The store holds 20 bytes (parameter `DEPTH`), and bytes are sent in the order they were accepted.
- R6: `in_ready` equals the inverse of `full`; a write presented while `full` is high is ignored and the occupancy does not grow.
- R7: `full` and `empty` show the occupancy reached after each clock edge: `full` when it equals `DEPTH`, `empty` when it is zero.
- R8: The cycle after the store is seen non-empty while idle, the block enters the start bit, takes one byte out of the store and raises `busy`; `busy` stays high until the stop bit ends.
- R9: If the store is non-empty when a stop bit ends, the next start bit begins in the next cycle, and `busy` does not drop.
- R10: A write and a removal on the same edge both take effect, and the written byte is sent later in its turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Store has a free slot |
| in_data | input | 8 | Byte offered by the host |
| full | output | 1 | Store occupancy equals DEPTH |
| empty | output | 1 | Store occupancy is zero |
| sub_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is being sent |

## Verification
Two things can happen on the same edge: the host pushes a byte into the store, and the sequencer pops a byte out of it. The sequencer pops either when it leaves idle or when a stop bit ends with data waiting. The bench provokes the collision in two ways. It streams writes every few cycles while the sub-tick strobe pulses every cycle, and it keeps offering bytes against a full store that is draining. A behavioural queue model predicts the occupancy flags and the exact line level on every clock. A lost, duplicated or reordered byte shows up as a wrong data bit on `tx_line` or as a wrong `full`/`empty` value.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txb_state_e;
endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
  parameter int DEPTH = 20,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txb_cell_cnt.sv
module txb_cell_cnt #(
  parameter int SUBS = 16,
  localparam int CLW = $clog2(SUBS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  output logic cell_end
);
  logic [CLW-1:0] cnt;
  logic           at_top;

  assign at_top   = (cnt == CLW'(SUBS - 1));
  assign cell_end = !hold && tick && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (hold)  cnt <= '0;
    else if (tick)  cnt <= at_top ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/txb_bit_cnt.sv
module txb_bit_cnt #(
  parameter int BCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           clr,
  output logic [BCW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (adv)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BCW       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           empty,
  input  logic           cell_end,
  input  logic [BCW-1:0] bit_cnt,
  output txb_state_e     state,
  output logic           pop,
  output logic           cell_hold,
  output logic           bit_adv,
  output logic           bit_clr
);
  txb_state_e nxt;
  logic       last_bit;

  assign last_bit = (bit_cnt == BCW'(DATA_BITS - 1));

  always_comb begin
    nxt = state;
    pop = 1'b0;
    unique case (state)
      ST_IDLE: if (!empty) begin
        nxt = ST_START;
        pop = 1'b1;
      end
      ST_START: if (cell_end) nxt = ST_DATA;
      ST_DATA:  if (cell_end && last_bit) nxt = ST_STOP;
      ST_STOP:  if (cell_end) begin
        if (!empty) begin
          nxt = ST_START;
          pop = 1'b1;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cell_hold = (state == ST_IDLE);
  assign bit_clr   = (state == ST_START);
  assign bit_adv   = (state == ST_DATA) && cell_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/uart_txb.sv
module uart_txb
  import txb_pkg::*;
#(
  parameter int DEPTH     = 20,
  parameter int DATA_BITS = 8,
  parameter int SUBS      = 16,
  parameter int BCW       = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 full,
  output logic                 empty,
  input  logic                 sub_tick,
  output logic                 tx_line,
  output logic                 busy
);
  logic [DATA_BITS-1:0] head;
  logic [DATA_BITS-1:0] shreg;
  logic [CW-1:0]        occ;
  logic [BCW-1:0]       bit_cnt;
  logic                 pop, cell_hold, cell_end, bit_adv, bit_clr;
  txb_state_e           state;

  txb_fifo #(.DEPTH(DEPTH), .W(DATA_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .push_data(in_data),
    .pop(pop), .head(head), .count(occ),
    .full(full), .empty(empty)
  );

  txb_cell_cnt #(.SUBS(SUBS)) u_cell (
    .clk(clk), .rst_n(rst_n),
    .hold(cell_hold), .tick(sub_tick), .cell_end(cell_end)
  );

  txb_bit_cnt #(.BCW(BCW)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .adv(bit_adv), .clr(bit_clr), .cnt(bit_cnt)
  );

  txb_ctrl #(.DATA_BITS(DATA_BITS), .BCW(BCW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .empty(empty), .cell_end(cell_end), .bit_cnt(bit_cnt),
    .state(state), .pop(pop), .cell_hold(cell_hold),
    .bit_adv(bit_adv), .bit_clr(bit_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     shreg <= '0;
    else if (pop)                   shreg <= head;
    else if (bit_adv)               shreg <= shreg >> 1;
  end

  always_comb begin
    unique case (state)
      ST_START: tx_line = 1'b0;
      ST_DATA:  tx_line = shreg[0];
      default:  tx_line = 1'b1;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign in_ready = !full;
endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
  parameter int DEPTH = 20,
  parameter int OCC_W = 5,
  parameter int BCW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sub_tick,
  input logic             in_valid,
  input logic             in_ready,
  input logic             full,
  input logic             empty,
  input logic             busy,
  input logic             tx_line,
  input logic [OCC_W-1:0] occ,
  input logic [BCW-1:0]   bit_cnt
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_line);

  // R3
  line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(sub_tick)) |-> $stable(tx_line));

  // R8
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!tx_line && $past(!empty)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  // R6
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid) |=> (occ <= $past(occ)));

  // R7
  empty_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(in_valid && in_ready)) |=> empty);

  // R2
  bit_count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BCW'(8));
endmodule

bind uart_txb txb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
  .in_valid(in_valid), .in_ready(in_ready),
  .full(full), .empty(empty), .busy(busy), .tx_line(tx_line),
  .occ(occ), .bit_cnt(bit_cnt)
);

// File: tb/tb_uart_txb.sv
`timescale 1ns/1ps
module tb_uart_txb;
  localparam int DEPTH = 20;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       sub_tick = 1'b0;
  logic       in_ready, full, empty, tx_line, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_per = 0;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  uart_txb dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .full(full), .empty(empty), .sub_tick(sub_tick),
    .tx_line(tx_line), .busy(busy)
  );

  // Reference model: 0 idle, 1 start, 2 data, 3 stop
  byte unsigned q[$];
  int   m_phase = 0;
  int   m_sub = 0;
  int   m_bits = 0;
  byte unsigned m_cur = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_phase = 0; m_sub = 0; m_bits = 0; m_cur = 0;
    end else begin
      int  pre;
      bit  endc;
      pre  = q.size();
      endc = 1'b0;
      if (m_phase == 0) begin
        if (pre > 0) begin
          m_cur = q.pop_front();
          m_phase = 1;
          m_sub = 0;
        end
      end else begin
        endc = sub_tick && (m_sub == 15);
        if (sub_tick) m_sub = (m_sub + 1) % 16;
        if (endc) begin
          case (m_phase)
            1: begin m_phase = 2; m_bits = 0; end
            2: begin
              m_bits++;
              if (m_bits == 8) m_phase = 3;
            end
            default: begin
              if (pre > 0) begin
                m_cur = q.pop_front();
                m_phase = 1;
              end else begin
                m_phase = 0;
              end
            end
          endcase
        end
      end
      if (in_valid && pre < DEPTH) q.push_back(in_data);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_tx;
      e_tx = (m_phase == 1) ? 1'b0 : (m_phase == 2) ? m_cur[m_bits] : 1'b1;
      check(tx_line === e_tx, "R2 R3 R4 R5 R9 R10 tx_line", int'(tx_line), int'(e_tx));
      check(busy === (m_phase != 0), "R8 busy", int'(busy), int'(m_phase != 0));
      check(full === (q.size() == DEPTH), "R6 R7 full", int'(full), int'(q.size() == DEPTH));
      check(empty === (q.size() == 0), "R7 R10 empty", int'(empty), int'(q.size() == 0));
      check(in_ready === (q.size() != DEPTH), "R6 in_ready", int'(in_ready), int'(q.size() != DEPTH));
    end
  end

  always @(negedge clk) begin
    if (tick_per == 0) begin
      sub_tick <= 1'b0;
      tcnt <= 0;
    end else begin
      sub_tick <= (tcnt == 0);
      tcnt <= (tcnt + 1 >= tick_per) ? 0 : tcnt + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic push(input byte unsigned b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (!(m_phase == 0 && q.size() == 0)) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_line === 1'b1, "R1 reset tx_line", int'(tx_line), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(empty === 1'b1, "R1 reset empty", int'(empty), 1);
    check(full === 1'b0, "R1 reset full", int'(full), 0);
    check(in_ready === 1'b1, "R1 reset in_ready", int'(in_ready), 1);

    // R2 single frame, slow sub-ticks
    tick_per = 4;
    push(8'hA5);
    drain();

    // R4 idle sub-ticks, then a frame
    tick_per = 3;
    repeat (50) @(negedge clk);
    push(8'h3C);
    drain();

    // R6 overflow: no sub-ticks, 25 writes into a 20-byte store
    tick_per = 0;
    for (int i = 0; i < 25; i++) push(8'(8'h11 * i + 8'h07));
    repeat (3) @(negedge clk);
    // R9 back-to-back drain
    tick_per = 1;
    drain();

    // R10 writes racing pops, store fills while draining
    tick_per = 1;
    for (int i = 0; i < 60; i++) begin
      push(8'(i * 37 + 5));
      repeat (6) @(negedge clk);
    end
    drain();

    // R3 odd sub-tick spacing
    tick_per = 5;
    push(8'h80);
    push(8'h01);
    drain();

    summary();
    $finish;
  end
endmodule